// File: doc/BRIEF.md
# DMA Sector Progress Tracker

This block keeps the bookkeeping for a disk transfer that a DMA engine moves in several chunks. A start pulse loads the starting block address, the amount of work and the mode. The DMA side then reports each finished chunk with a pulse. With that pulse it also offers the length of the next chunk. The block accounts the chunk it issued last, advances its address and remaining-work counters, and decides whether the command is finished. It then either issues a request for the offered chunk, with the 512-byte sector address where that chunk begins, or ends the DMA phase.

Two accounting modes exist. In disk mode the unit is a 512-byte sector, and a partial sector counts as a whole one. In packet mode the unit is a 2048-byte block. A byte offset inside the current block is carried from chunk to chunk, so chunks need not be block aligned. The request address is then expressed in 512-byte units: four per block plus the sub-block offset. Completion sets a ready/seek-complete status and raises an interrupt. An error reported with a chunk aborts the transfer.

Top module: `dma_sector_tracker`

## Requirements
- R1: In disk mode, a completed chunk of S bytes moves the block address forward by ceil(S/512) and lowers the remaining-sector count by the same amount, saturating at zero.
- R2: In disk mode, when the remaining-sector count becomes zero, `done` goes to 1, `status` becomes 8'h50 (bit 6 ready, bit 4 seek complete) and `irq` goes to 1.
- R3: In packet mode, a completed chunk of S bytes is added to the carried byte offset. The block address advances by (offset+S)/2048, and the offset keeps (offset+S) mod 2048.
- R4: In packet mode, the remaining byte count drops by S. Once it is zero or would go negative, the command completes, with `done`=1, `status`=8'h50 and `irq`=1.
- R5: In packet mode, `reqAddr` for an issued chunk equals 4 × block address + (offset / 512), where the block address and offset are the values after accounting.
- R6: In disk mode the byte offset is zero, so `startOffset` is ignored and `reqAddr` equals the block address.
- R7: An offered chunk length of zero gives a one-cycle `dmaEnd` pulse with no `reqValid`, and the block goes idle. A non-zero length gives a one-cycle `reqValid` with no `dmaEnd`.
- R8: The start pulse accounts nothing. The first request uses the start address unchanged, and a start with zero work completes at once.
- R9: A chunk-done pulse with `chunkErr` set sets `status` to 8'h41 (ready plus error bit 0), raises `irq`, clears `done`, pulses `dmaEnd` and makes the block idle.
- R10: The command code sampled at start appears on `reqCmd` and does not change until the next start.
- R11: A chunk-done pulse while idle is ignored. It gives no request, and `reqAddr` and `status` do not change.
- R12: After reset, `status`=0, `irq`=0, `done`=0, `reqValid`=0 and `dmaEnd`=0. A start sets `status` to 8'h80 (busy), clears `irq` and `done`, and makes the block active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a command and offers the first chunk |
| modePacket | input | 1 | 1 = packet mode (2048-byte blocks), 0 = disk mode (512-byte sectors) |
| cmdIn | input | 2 | Command code (read, write or trim), sampled at start |
| startLba | input | LBA_W | Starting block address |
| startSectors | input | CNT_W | Sector count for disk mode |
| startPktBytes | input | PKT_W | Byte count for packet mode |
| startOffset | input | 11 | Initial byte offset inside a block, packet mode only |
| chunkDone | input | 1 | The chunk issued last has finished |
| chunkErr | input | 1 | That chunk failed (valid with chunkDone) |
| chunkLen | input | LEN_W | Length of the next chunk offered (valid with startPulse or chunkDone) |
| reqValid | output | 1 | One-cycle pulse: request for the offered chunk |
| reqAddr | output | LBA_W+2 | Sector address (512-byte units) for the request |
| reqCmd | output | 2 | Latched command code |
| dmaEnd | output | 1 | One-cycle pulse: DMA phase over |
| done | output | 1 | Command completed successfully |
| irq | output | 1 | Interrupt, held until the next start |
| status | output | 8 | Status byte |

## Verification
A wrong offset carry or a missing round-up does not stay hidden: it changes `reqAddr` at the very next issued request, one cycle after the chunk-done pulse. The table therefore checks the address after both the start and the second chunk, using unaligned offsets and odd lengths. A counter that is off by one shows only at the completion point, as `done` or `status` arriving one chunk early or late. The vectors therefore put that point both on an exact boundary and past an overshoot. Error, idle and zero-length cases each show at the port in the cycle after their pulse.

// File: rtl/dst_pkg.sv
package dst_pkg;
  typedef struct packed {
    logic load;     // latch start values
    logic account;  // account previously issued chunk
    logic issue;    // issue offered chunk
    logic fail;     // error path
    logic endDma;   // end of DMA phase
  } ctrlStrobe_t;

  localparam logic [7:0] STAT_BUSY  = 8'h80;
  localparam logic [7:0] STAT_READY = 8'h40;
  localparam logic [7:0] STAT_SEEK  = 8'h10;
  localparam logic [7:0] STAT_ERR   = 8'h01;
  localparam logic [7:0] STAT_OK    = STAT_READY | STAT_SEEK;
  localparam logic [7:0] STAT_FAIL  = STAT_READY | STAT_ERR;
endpackage

// File: rtl/dst_datapath.sv
module dst_datapath
  import dst_pkg::*;
#(
  parameter int LBA_W = 28,
  parameter int CNT_W = 16,
  parameter int PKT_W = 20,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        st,
  input  logic               modeIn,
  input  logic [1:0]         cmdIn,
  input  logic [LBA_W-1:0]   startLba,
  input  logic [CNT_W-1:0]   startSectors,
  input  logic [PKT_W-1:0]   startPktBytes,
  input  logic [10:0]        startOffset,
  input  logic [LEN_W-1:0]   chunkLen,
  output logic [LBA_W+1:0]   reqAddr,
  output logic [1:0]         reqCmd,
  output logic               doneNext
);
  localparam int SUM_W = (LEN_W > 11 ? LEN_W : 11) + 1;
  localparam int SEC_W = LEN_W + 1;

  logic [LBA_W-1:0] lbaQ, baseLba, lbaN;
  logic [CNT_W-1:0] cntQ, baseCnt, cntN;
  logic [PKT_W-1:0] remQ, baseRem, remN;
  logic [10:0]      offQ, baseOff, offN;
  logic [LEN_W-1:0] prevQ, acctSize;
  logic             modeQ, modeEff;
  logic [1:0]       cmdQ;
  logic [LBA_W+1:0] addrQ, addrN;
  logic [SEC_W-1:0] secs;
  logic [SUM_W-1:0] sum;

  always_comb begin
    modeEff  = st.load ? modeIn : modeQ;
    baseLba  = st.load ? startLba : lbaQ;
    baseCnt  = st.load ? startSectors : cntQ;
    baseRem  = st.load ? startPktBytes : remQ;
    baseOff  = st.load ? (modeIn ? startOffset : 11'd0) : offQ;
    acctSize = st.account ? prevQ : '0;
    secs     = (SEC_W'(acctSize) + SEC_W'(511)) >> 9;
    sum      = SUM_W'(baseOff) + SUM_W'(acctSize);
    lbaN     = baseLba;
    cntN     = baseCnt;
    remN     = baseRem;
    offN     = baseOff;
    if (modeEff) begin
      lbaN = baseLba + LBA_W'(sum >> 11);
      offN = sum[10:0];
      if (PKT_W'(acctSize) >= baseRem) remN = '0;
      else                             remN = baseRem - PKT_W'(acctSize);
    end else begin
      lbaN = baseLba + LBA_W'(secs);
      offN = 11'd0;
      if (CNT_W'(secs) >= baseCnt || (SEC_W > CNT_W && (secs >> CNT_W) != 0)) cntN = '0;
      else cntN = baseCnt - CNT_W'(secs);
    end
    doneNext = modeEff ? (remN == '0) : (cntN == '0);
    if (modeEff) addrN = {lbaN, 2'b00} + (LBA_W+2)'(offN[10:9]);
    else         addrN = (LBA_W+2)'(lbaN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lbaQ  <= '0;
      cntQ  <= '0;
      remQ  <= '0;
      offQ  <= '0;
      prevQ <= '0;
      modeQ <= 1'b0;
      cmdQ  <= 2'd0;
      addrQ <= '0;
    end else begin
      if (st.load) begin
        modeQ <= modeIn;
        cmdQ  <= cmdIn;
      end
      if (st.load || st.account) begin
        lbaQ <= lbaN;
        cntQ <= cntN;
        remQ <= remN;
        offQ <= offN;
      end
      if (st.issue) begin
        prevQ <= chunkLen;
        addrQ <= addrN;
      end else if (st.load) begin
        prevQ <= '0;
      end
    end
  end

  assign reqAddr = addrQ;
  assign reqCmd  = cmdQ;
endmodule

// File: rtl/dst_control.sv
module dst_control
  import dst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        chunkDone,
  input  logic        chunkErr,
  input  logic        lenZero,
  input  logic        doneNext,
  output ctrlStrobe_t st,
  output logic        active,
  output logic        reqValid,
  output logic        dmaEnd,
  output logic        done,
  output logic        irq,
  output logic [7:0]  status
);
  logic evt, okEvt;

  always_comb begin
    evt        = startPulse || (active && chunkDone);
    st.load    = startPulse;
    st.fail    = !startPulse && active && chunkDone && chunkErr;
    st.account = !startPulse && active && chunkDone && !chunkErr;
    okEvt      = evt && !st.fail;
    st.issue   = okEvt && !lenZero;
    st.endDma  = st.fail || (okEvt && lenZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      reqValid <= 1'b0;
      dmaEnd   <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
      status   <= 8'h00;
    end else begin
      reqValid <= st.issue;
      dmaEnd   <= st.endDma;
      if (st.load) begin
        active <= 1'b1;
        done   <= 1'b0;
        irq    <= 1'b0;
        status <= STAT_BUSY;
      end
      if ((st.load || st.account) && doneNext) begin
        done   <= 1'b1;
        irq    <= 1'b1;
        status <= STAT_OK;
      end
      if (st.fail) begin
        active <= 1'b0;
        done   <= 1'b0;
        irq    <= 1'b1;
        status <= STAT_FAIL;
      end else if (st.endDma) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_sector_tracker.sv
module dma_sector_tracker
  import dst_pkg::*;
#(
  parameter int LBA_W = 28,
  parameter int CNT_W = 16,
  parameter int PKT_W = 20,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             modePacket,
  input  logic [1:0]       cmdIn,
  input  logic [LBA_W-1:0] startLba,
  input  logic [CNT_W-1:0] startSectors,
  input  logic [PKT_W-1:0] startPktBytes,
  input  logic [10:0]      startOffset,
  input  logic             chunkDone,
  input  logic             chunkErr,
  input  logic [LEN_W-1:0] chunkLen,
  output logic             reqValid,
  output logic [LBA_W+1:0] reqAddr,
  output logic [1:0]       reqCmd,
  output logic             dmaEnd,
  output logic             done,
  output logic             irq,
  output logic [7:0]       status
);
  ctrlStrobe_t st;
  logic        doneNext;
  logic        active;

  dst_control u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chunkDone(chunkDone),
    .chunkErr(chunkErr), .lenZero(chunkLen == '0), .doneNext(doneNext),
    .st(st), .active(active), .reqValid(reqValid), .dmaEnd(dmaEnd),
    .done(done), .irq(irq), .status(status)
  );

  dst_datapath #(.LBA_W(LBA_W), .CNT_W(CNT_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .modeIn(modePacket), .cmdIn(cmdIn),
    .startLba(startLba), .startSectors(startSectors), .startPktBytes(startPktBytes),
    .startOffset(startOffset), .chunkLen(chunkLen), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .doneNext(doneNext)
  );
endmodule

// File: rtl/dst_checker.sv
module dst_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       chunkDone,
  input logic       chunkErr,
  input logic       active,
  input logic       reqValid,
  input logic       dmaEnd,
  input logic       done,
  input logic [1:0] reqCmd,
  input logic [7:0] status
);
  AST_REQ_END_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && dmaEnd)); // R7
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> status == 8'h50); // R2
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (chunkDone && chunkErr && active && !startPulse) |=> (dmaEnd && status == 8'h41 && !active)); // R9
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (chunkDone && !active && !startPulse) |=> (!reqValid && !dmaEnd)); // R11
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(reqCmd)); // R10
endmodule

bind dma_sector_tracker dst_checker u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .chunkDone(chunkDone),
  .chunkErr(chunkErr), .active(active), .reqValid(reqValid), .dmaEnd(dmaEnd),
  .done(done), .reqCmd(reqCmd), .status(status)
);

// File: tb/tb_dma_sector_tracker.sv
module tb_dma_sector_tracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0, modePacket = 1'b0, chunkDone = 1'b0, chunkErr = 1'b0;
  logic [1:0]  cmdIn = 2'd0;
  logic [27:0] startLba = '0;
  logic [15:0] startSectors = '0;
  logic [19:0] startPktBytes = '0;
  logic [10:0] startOffset = '0;
  logic [15:0] chunkLen = '0;
  logic        reqValid, dmaEnd, done, irq;
  logic [29:0] reqAddr;
  logic [1:0]  reqCmd;
  logic [7:0]  status;
  int checks = 0, failures = 0, cyc = 0;

  always #4 clk = ~clk;

  dma_sector_tracker dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modePacket(modePacket),
    .cmdIn(cmdIn), .startLba(startLba), .startSectors(startSectors),
    .startPktBytes(startPktBytes), .startOffset(startOffset), .chunkDone(chunkDone),
    .chunkErr(chunkErr), .chunkLen(chunkLen), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .dmaEnd(dmaEnd), .done(done), .irq(irq), .status(status)
  );

  // mode, lba, sectors/bytes, offset, len1, len2, addr after start, addr after chunk, done
  localparam int N = 6;
  localparam int T_MODE [N] = '{0, 0, 1, 1, 1, 0};
  localparam int T_LBA  [N] = '{100, 7, 10, 5, 0, 50};
  localparam int T_CNT  [N] = '{4, 3, 4096, 3000, 100, 1};
  localparam int T_OFF  [N] = '{0, 0, 0, 1536, 0, 0};
  localparam int T_LEN1 [N] = '{1024, 1000, 2048, 1000, 512, 1};
  localparam int T_LEN2 [N] = '{1024, 600, 2048, 512, 512, 8};
  localparam int T_A1   [N] = '{100, 7, 40, 23, 0, 50};
  localparam int T_A2   [N] = '{102, 9, 44, 24, 1, 51};
  localparam int T_DONE [N] = '{0, 0, 0, 0, 1, 1};

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doStart(input int mode, input int lba, input int cnt, input int off,
                         input int len, input int cmd);
    @(negedge clk);
    modePacket = mode[0]; startLba = 28'(lba); startSectors = 16'(cnt);
    startPktBytes = 20'(cnt); startOffset = 11'(off); chunkLen = 16'(len);
    cmdIn = 2'(cmd); startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic doChunk(input int len, input logic err);
    @(negedge clk);
    chunkLen = 16'(len); chunkErr = err; chunkDone = 1'b1;
    @(negedge clk);
    chunkDone = 1'b0; chunkErr = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [29:0] held;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 status", status, 0); check("R12 irq", irq, 0);
    check("R12 done", done, 0); check("R12 reqValid", reqValid, 0);
    check("R12 dmaEnd", dmaEnd, 0);
    rstN = 1'b1;

    for (int i = 0; i < N; i++) begin
      doStart(T_MODE[i], T_LBA[i], T_CNT[i], T_OFF[i], T_LEN1[i], 1);
      check("R8 first addr", reqAddr, T_A1[i]);
      check("R7 issue", reqValid, 1);
      check("R12 busy", status, 8'h80);
      doChunk(T_LEN2[i], 1'b0);
      check(T_MODE[i] != 0 ? "R3 R5 addr" : "R1 addr", reqAddr, T_A2[i]);
      check(T_MODE[i] != 0 ? "R4 done" : "R2 done", done, T_DONE[i]);
      check(T_MODE[i] != 0 ? "R4 status" : "R2 status", status, T_DONE[i] != 0 ? 8'h50 : 8'h80);
      check("R2 irq", irq, T_DONE[i]);
      doChunk(0, 1'b0);
      check("R7 end", dmaEnd, 1);
      check("R7 no req", reqValid, 0);
    end

    // R8 zero work completes at start
    doStart(0, 9, 0, 0, 512, 0);
    check("R8 done", done, 1); check("R8 status", status, 8'h50);
    check("R8 addr", reqAddr, 9);
    doChunk(0, 1'b0);

    // R7 zero-length first offer, then R11 idle chunk ignored
    doStart(0, 60, 4, 0, 0, 0);
    check("R7 end at start", dmaEnd, 1); check("R7 no req", reqValid, 0);
    held = reqAddr;
    doChunk(512, 1'b0);
    check("R11 no req", reqValid, 0); check("R11 addr", reqAddr, held);
    check("R11 status", status, 8'h80);

    // R9 error path
    doStart(0, 30, 8, 0, 512, 0);
    doChunk(512, 1'b1);
    check("R9 status", status, 8'h41); check("R9 irq", irq, 1);
    check("R9 dmaEnd", dmaEnd, 1); check("R9 done", done, 0);
    doChunk(512, 1'b0);
    check("R9 idle after", reqValid, 0);

    // R10 command latched
    doStart(0, 70, 8, 0, 512, 2);
    cmdIn = 2'd1;
    doChunk(512, 1'b0);
    check("R10 cmd", reqCmd, 2);
    doChunk(0, 1'b0);

    // R6 disk mode ignores start offset
    doStart(0, 20, 8, 700, 512, 0);
    check("R6 addr", reqAddr, 20);
    doChunk(512, 1'b0);
    check("R6 addr2", reqAddr, 21);
    doChunk(0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule